// File: doc/BRIEF.md
# Speculative Load Violation Checker

This block keeps a small table of loads that were issued ahead of older stores. When a load issues speculatively, the scheduler writes an entry holding the load's effective address, its reorder-buffer ID and the ID of the store that forwarded its data. A load that read memory instead of a forwarding store is written with a producer value that no store ID can equal. Stores may issue out of order. The table is searched only when a store retires, using that store's address. Every matching entry then has its exception flag cleared if the retiring store is the entry's recorded producer, and set if it is any other store.

When a load retires, the table is searched by load ID. If the entry's exception flag is set, the block raises a rollback in the same cycle that names that load as the restart point, and the whole table is emptied at the next edge. If the flag is clear, only that entry is freed. A flush input empties the table. A full output tells the issue logic to stop speculating while every entry is in use.

Top module: `spec_load_checker`

## Requirements
- R1: An accepted allocate writes the address, load ID and producer ID into the lowest-numbered free entry, with its exception flag clear, and the occupancy grows by one.
- R2: The producer field is ROB_W+1 bits wide. A value with its top bit set marks a load served from memory, and a retiring store never counts as that load's producer.
- R3: A retiring store whose word address (address bits above bit 1) equals an entry's address clears that entry's flag if the store ID equals the entry's producer, and sets it otherwise. Entries at other addresses are unchanged. A later probe overrides an earlier one.
- R4: A store probe never changes which entries are occupied.
- R5: A retiring load whose flag is set, counting a probe in the same cycle, drives rollback high in that cycle with rollback_load_id equal to the retiring ID. At the next edge every entry is emptied.
- R6: A retiring load whose flag is clear gives no rollback, and only its own entry is freed.
- R7: full is high exactly when every entry is occupied. An allocate while full is dropped.
- R8: flush empties every entry at the next edge and takes priority over an allocate in the same cycle.
- R9: When a probe and an allocate for the same word arrive in the same cycle, the probe acts first, so the new entry starts with a clear flag.
- R10: Address bits 1 and 0 take no part in matching.
- R11: Retiring a load ID that is not in the table gives no rollback and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Speculative load issue |
| alloc_addr | input | ADDR_W | Effective address of the load |
| alloc_load_id | input | ROB_W | Reorder-buffer ID of the load |
| alloc_prod_id | input | ROB_W+1 | Forwarding store ID; top bit set means data came from memory |
| full | output | 1 | Every entry in use |
| probe_valid | input | 1 | Store retirement |
| probe_addr | input | ADDR_W | Address of the retiring store |
| probe_store_id | input | ROB_W | Reorder-buffer ID of the retiring store |
| ret_valid | input | 1 | Load retirement |
| ret_load_id | input | ROB_W | Reorder-buffer ID of the retiring load |
| rollback | output | 1 | Retiring load must be refetched |
| rollback_load_id | output | ROB_W | Restart point for the rollback |
| flush | input | 1 | Empty the table |

## Verification
The assertions assume that load IDs present in the table are unique, that allocate is raised only when the issue logic intends to speculate, and that rollback only follows a load retirement. The directed tasks allocate distinct IDs, flush the table before each scenario, and raise at most one retirement per cycle. With these inputs, changes in occupancy depend only on allocate, retirement and flush, which is what the checker tracks.

// File: rtl/ldchk_pkg.sv
package ldchk_pkg;
    // Address bits below this index select a byte within a word and are not compared.
    parameter int unsigned WORD_OFS = 2;

    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2
    } probe_act_e;
endpackage

// File: rtl/ldchk_pick_free.sv
module ldchk_pick_free #(
    parameter int unsigned N = 16,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        // Scan downward so the lowest free slot is the one kept.
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ldchk_id_lookup.sv
module ldchk_id_lookup #(
    parameter int unsigned N    = 16,
    parameter int unsigned ID_W = 6,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]           vld,
    input  logic [N-1:0][ID_W-1:0] ids,
    input  logic [ID_W-1:0]        key,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld[i] && ids[i] == key) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ldchk_probe_cell.sv
module ldchk_probe_cell
    import ldchk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ROB_W  = 6,
    localparam int unsigned PROD_W = ROB_W + 1
) (
    input  logic              ent_vld,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [PROD_W-1:0] ent_prod,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic [ROB_W-1:0]  probe_store_id,
    output probe_act_e        act
);
    logic same_word;
    logic is_producer;

    assign same_word   = ent_addr[ADDR_W-1:WORD_OFS] == probe_addr[ADDR_W-1:WORD_OFS];
    // The top bit of a store ID is zero, so a memory-served entry never matches.
    assign is_producer = ent_prod == {1'b0, probe_store_id};

    always_comb begin
        act = ACT_KEEP;
        if (ent_vld && probe_valid && same_word) begin
            act = is_producer ? ACT_CLEAR : ACT_SET;
        end
    end
endmodule

// File: rtl/spec_load_checker.sv
module spec_load_checker
    import ldchk_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ROB_W   = 6,
    localparam int unsigned PROD_W = ROB_W + 1,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [ROB_W-1:0]  alloc_load_id,
    input  logic [PROD_W-1:0] alloc_prod_id,
    output logic              full,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic [ROB_W-1:0]  probe_store_id,
    input  logic              ret_valid,
    input  logic [ROB_W-1:0]  ret_load_id,
    output logic              rollback,
    output logic [ROB_W-1:0]  rollback_load_id,
    input  logic              flush
);
    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0]             exc;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][ROB_W-1:0]  lid;
        logic [ENTRIES-1:0][PROD_W-1:0] prod;
    } table_t;

    table_t st_d, st_q;

    probe_act_e [ENTRIES-1:0] act;
    logic [ENTRIES-1:0]       exc_now;
    logic                     free_found;
    logic [IDX_W-1:0]         free_idx;
    logic                     ret_hit;
    logic [IDX_W-1:0]         ret_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        ldchk_probe_cell #(
            .ADDR_W(ADDR_W),
            .ROB_W (ROB_W)
        ) u_cell (
            .ent_vld       (st_q.vld[g]),
            .ent_addr      (st_q.addr[g]),
            .ent_prod      (st_q.prod[g]),
            .probe_valid   (probe_valid),
            .probe_addr    (probe_addr),
            .probe_store_id(probe_store_id),
            .act           (act[g])
        );

        always_comb begin
            unique case (act[g])
                ACT_SET:   exc_now[g] = 1'b1;
                ACT_CLEAR: exc_now[g] = 1'b0;
                default:   exc_now[g] = st_q.exc[g];
            endcase
        end
    end

    ldchk_pick_free #(.N(ENTRIES)) u_free (
        .busy (st_q.vld),
        .found(free_found),
        .idx  (free_idx)
    );

    ldchk_id_lookup #(.N(ENTRIES), .ID_W(ROB_W)) u_lookup (
        .vld(st_q.vld),
        .ids(st_q.lid),
        .key(ret_load_id),
        .hit(ret_hit),
        .idx(ret_idx)
    );

    assign full             = &st_q.vld;
    assign rollback         = ret_valid && ret_hit && exc_now[ret_idx];
    assign rollback_load_id = ret_load_id;

    always_comb begin
        st_d     = st_q;
        // Store probes act before this cycle's allocate.
        st_d.exc = exc_now;

        if (ret_valid && ret_hit && !exc_now[ret_idx]) begin
            st_d.vld[ret_idx] = 1'b0;
        end

        if (alloc_valid && free_found) begin
            st_d.vld[free_idx]  = 1'b1;
            st_d.exc[free_idx]  = 1'b0;
            st_d.addr[free_idx] = alloc_addr;
            st_d.lid[free_idx]  = alloc_load_id;
            st_d.prod[free_idx] = alloc_prod_id;
        end

        if (flush || rollback) begin
            st_d.vld = '0;
            st_d.exc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ldchk_checker.sv
module ldchk_checker #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         alloc_valid,
    input logic         probe_valid,
    input logic         ret_valid,
    input logic         flush,
    input logic         full,
    input logic         rollback,
    input logic [N-1:0] vld
);
    assert_alloc_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !full && !flush && !ret_valid)
        |=> $countones(vld) == $past($countones(vld)) + 1);

    assert_probe_keeps_occupancy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && !alloc_valid && !ret_valid && !flush) |=> $stable(vld));

    assert_rollback_from_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> ret_valid);

    assert_rollback_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> vld == '0);

    assert_full_drops_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ret_valid && !flush) |=> $stable(vld));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0 && !full));
endmodule

bind spec_load_checker ldchk_checker #(.N(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_valid(alloc_valid),
    .probe_valid(probe_valid),
    .ret_valid  (ret_valid),
    .flush      (flush),
    .full       (full),
    .rollback   (rollback),
    .vld        (st_q.vld)
);

// File: tb/sim_spec_load_checker.sv
module sim_spec_load_checker;
    localparam int unsigned ENTRIES = 16;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned ROB_W   = 6;
    localparam logic [ROB_W:0] FROM_MEM = 7'h40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic [ROB_W-1:0]  alloc_load_id = '0;
    logic [ROB_W:0]    alloc_prod_id = '0;
    logic              full;
    logic              probe_valid = 1'b0;
    logic [ADDR_W-1:0] probe_addr = '0;
    logic [ROB_W-1:0]  probe_store_id = '0;
    logic              ret_valid = 1'b0;
    logic [ROB_W-1:0]  ret_load_id = '0;
    logic              rollback;
    logic [ROB_W-1:0]  rollback_load_id;
    logic              flush = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spec_load_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .ROB_W(ROB_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .alloc_load_id(alloc_load_id), .alloc_prod_id(alloc_prod_id),
        .full(full),
        .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_store_id(probe_store_id),
        .ret_valid(ret_valid), .ret_load_id(ret_load_id),
        .rollback(rollback), .rollback_load_id(rollback_load_id),
        .flush(flush)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_all();
        alloc_valid = 1'b0; probe_valid = 1'b0; ret_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic finish_cycle();
        @(posedge clk); #1; idle_all();
    endtask

    task automatic set_alloc(input logic [ADDR_W-1:0] a, input int id, input logic [ROB_W:0] p);
        alloc_valid = 1'b1; alloc_addr = a; alloc_load_id = ROB_W'(id); alloc_prod_id = p;
    endtask

    task automatic set_probe(input logic [ADDR_W-1:0] a, input int sid);
        probe_valid = 1'b1; probe_addr = a; probe_store_id = ROB_W'(sid);
    endtask

    task automatic do_alloc(input logic [ADDR_W-1:0] a, input int id, input logic [ROB_W:0] p);
        @(negedge clk); set_alloc(a, id, p); finish_cycle();
    endtask

    task automatic do_probe(input logic [ADDR_W-1:0] a, input int sid);
        @(negedge clk); set_probe(a, sid); finish_cycle();
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1; finish_cycle();
    endtask

    task automatic do_retire(input int id, input int exp_rb, input string req);
        @(negedge clk);
        ret_valid = 1'b1; ret_load_id = ROB_W'(id);
        #1;
        chk(int'(rollback), exp_rb, req);
        if (exp_rb == 1) chk(int'(rollback_load_id), id, req);
        finish_cycle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(int'(full), 0, "R7 reset full");
        ret_valid = 1'b1; ret_load_id = 6'd3; #1;
        chk(int'(rollback), 0, "R11 reset retire");
        finish_cycle();
    endtask

    task automatic t_producer();
        do_flush();
        do_alloc(32'h100, 5, 7'd3);
        do_probe(32'h100, 3);
        do_retire(5, 0, "R3 producer clears");
        do_probe(32'h100, 9);
        do_retire(5, 0, "R6 entry freed");
    endtask

    task automatic t_other_store();
        do_flush();
        do_alloc(32'h200, 6, 7'd3);
        do_probe(32'h200, 4);
        do_retire(6, 1, "R5 non-producer rollback");
        do_alloc(32'h300, 7, FROM_MEM);
        do_alloc(32'h300, 8, FROM_MEM);
        do_probe(32'h300, 1);
        do_retire(7, 1, "R5 first load");
        do_retire(8, 0, "R5 table emptied");
    endtask

    task automatic t_order();
        do_flush();
        do_alloc(32'h400, 9, 7'd2);
        do_probe(32'h400, 5);
        do_probe(32'h400, 2);
        do_retire(9, 0, "R3 later producer clears");
        do_alloc(32'h440, 10, 7'd2);
        do_probe(32'h440, 2);
        do_probe(32'h440, 5);
        do_retire(10, 1, "R3 later other store sets");
    endtask

    task automatic t_memory();
        do_flush();
        do_alloc(32'h480, 11, FROM_MEM | 7'd2);
        @(negedge clk);
        set_probe(32'h480, 2);
        ret_valid = 1'b1; ret_load_id = 6'd11;
        #1;
        chk(int'(rollback), 1, "R2 memory-served load, same-cycle probe R5");
        finish_cycle();
    endtask

    task automatic t_address();
        do_flush();
        do_alloc(32'h500, 12, FROM_MEM);
        do_probe(32'h504, 1);
        do_retire(12, 0, "R3 other word untouched");
        do_alloc(32'h600, 13, FROM_MEM);
        do_probe(32'h603, 1);
        do_retire(13, 1, "R10 byte bits ignored");
    endtask

    task automatic t_full();
        do_flush();
        for (int i = 0; i < ENTRIES; i++) begin
            do_alloc(32'h1000 + 32'(i) * 4, i, FROM_MEM);
            @(negedge clk);
            chk(int'(full), (i == ENTRIES - 1) ? 1 : 0, "R7 full flag");
        end
        do_alloc(32'h2000, 40, FROM_MEM);
        do_probe(32'h2000, 1);
        @(negedge clk);
        chk(int'(full), 1, "R4 probe keeps occupancy");
        do_retire(40, 0, "R7 alloc while full dropped");
        do_retire(0, 0, "R6 retire clean load");
        @(negedge clk);
        chk(int'(full), 0, "R6 one entry freed");
        do_flush();
        do_probe(32'h1004, 1);
        do_retire(1, 0, "R8 flush empties");
    endtask

    task automatic t_flush_alloc();
        do_flush();
        @(negedge clk);
        flush = 1'b1;
        set_alloc(32'h700, 20, FROM_MEM);
        finish_cycle();
        do_probe(32'h700, 1);
        do_retire(20, 0, "R8 flush beats alloc");
    endtask

    task automatic t_same_cycle();
        do_flush();
        @(negedge clk);
        set_alloc(32'h800, 21, FROM_MEM);
        set_probe(32'h800, 3);
        finish_cycle();
        do_retire(21, 0, "R9 probe before alloc");
        do_alloc(32'h840, 22, FROM_MEM);
        @(negedge clk);
        set_alloc(32'h840, 23, FROM_MEM);
        set_probe(32'h840, 3);
        finish_cycle();
        do_retire(23, 0, "R9 new entry clear");
        do_retire(22, 1, "R9 older entry set");
    endtask

    task automatic t_absent();
        do_flush();
        do_alloc(32'h900, 24, FROM_MEM);
        do_probe(32'h900, 2);
        do_retire(50, 0, "R11 absent id");
        do_retire(24, 1, "R11 table intact");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected 0 cycles left", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_producer();
        t_other_store();
        t_order();
        t_memory();
        t_address();
        t_full();
        t_flush_alloc();
        t_same_cycle();
        t_absent();
        done = 1'b1;
        summary();
    end
endmodule